// File: doc/BRIEF.md
# Alphanumeric Segment Frame Latch

This block gathers segment patterns for two rows of 16-segment display digits from a small byte-wide write port. Software first loads a digit position, then merges a low byte and a high byte into that digit's 16-bit word in either row. Writes are merged by bitwise OR, so several writes within one frame build up a pattern and never clear a bit.

A word store holds 40 entries. Row 1 at position `p` uses entry `p`, and row 2 uses entry `p + 20`. When a frame tick arrives, entries 0..15 and 20..35 are each passed through a fixed bit reordering and latched onto a 32-word frame output. A one-cycle valid strobe marks the new frame. In the same cycle the whole store is cleared, ready for the next frame. Scanning the display and driving its segments are left to downstream logic.

Top module: `alnum_frame_latch`

## Requirements
- R1: With `wr_en` high, select 0 loads the position register from `wr_data[4:0]`; bits 7:5 are ignored. The position register holds between such writes and is 0 after reset.
- R2: Select 1 ORs `wr_data` into bits 7:0 of store entry `pos`, and select 2 ORs it into bits 15:8 of the same entry (row 1).
- R3: Select 3 and select 4 do the same for bits 7:0 and bits 15:8 of entry `pos + 20` (row 2). A write whose entry index is 40 or more is dropped.
- R4: Within a frame, writes only ever set bits. Repeated writes to the same byte give the OR of all the data written.
- R5: In the cycle after `frame_tick`, output word `k` (bits `16k+15:16k`) holds entry `k` as it was at the tick, for k = 0..15. Output word `16+k` holds entry `20+k` at the tick. `frame_valid` is high in that same cycle.
- R6: `frame_valid` is high only in the cycle after a tick. `frame_words` does not change in any cycle that does not follow a tick.
- R7: A tick clears every store entry. A write in the same cycle as a tick is absent from the frame being published and is present in the new frame.
- R8: Output bits 15 down to 0 of a published word take the stored bits 7, 15, 12, 10, 8, 14, 13, 9, 11, 6, 5, 4, 3, 2, 1, 0, in that order.
- R9: Row 1 positions 16..19 reach entries that are never published. Row 1 positions 20..31 alias row 2 positions 0..11. Neither case raises any indication.
- R10: After reset, `frame_words` is all zero, `frame_valid` is low and the store is empty.
- R11: Select values 5, 6 and 7 change neither the store nor the position register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_sel | input | 3 | Write target: 0 position, 1 row-1 low, 2 row-1 high, 3 row-2 low, 4 row-2 high |
| wr_data | input | 8 | Write data |
| frame_tick | input | 1 | Frame boundary pulse: publish, then clear |
| frame_words | output | 512 | 32 reordered digit words, word k at bits 16k+15:16k |
| frame_valid | output | 1 | One-cycle strobe marking a new frame |

## Verification
The hardest case to reach is a write that lands in the same cycle as a frame tick. The same write must be missing from the frame being published and present in the frame that follows. The bench drives both inputs on one falling edge and checks two successive frames against its own model of the store.

Position aliasing is covered by an exhaustive sweep over all 32 position codes. In each step both rows are written, so row-1 writes from position 20 upward merge into row-2 words, and row-2 writes from position 20 upward must vanish. The bit reordering is checked by walking a single set bit through all 16 stored bit positions.

// File: rtl/alnum_pkg.sv
package alnum_pkg;

   localparam int SEG_W = 16;

   typedef enum logic [2:0] {
      SEL_POS   = 3'd0,
      SEL_R1_LO = 3'd1,
      SEL_R1_HI = 3'd2,
      SEL_R2_LO = 3'd3,
      SEL_R2_HI = 3'd4
   } wr_sel_e;

   // Fixed segment reordering applied when a stored word is published.
   function automatic logic [SEG_W-1:0] seg_permute(input logic [SEG_W-1:0] w);
      logic [SEG_W-1:0] r;
      r[15] = w[7];
      r[14] = w[15];
      r[13] = w[12];
      r[12] = w[10];
      r[11] = w[8];
      r[10] = w[14];
      r[9]  = w[13];
      r[8]  = w[9];
      r[7]  = w[11];
      r[6:0] = w[6:0];
      return r;
   endfunction

endpackage

// File: rtl/alnum_reg_decode.sv
module alnum_reg_decode
   import alnum_pkg::*;
#(
   parameter int POS_W       = 5,
   parameter int STORE_WORDS = 40,
   parameter int ROW_OFFSET  = 20,
   parameter int DATA_W      = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [2:0]             wr_sel,
   input  logic [DATA_W-1:0]      wr_data,
   output logic [POS_W-1:0]       pos_q,
   output logic [STORE_WORDS-1:0] lo_en,
   output logic [STORE_WORDS-1:0] hi_en
);
   localparam int MAX_IDX = (1 << POS_W) - 1 + ROW_OFFSET;
   localparam int IDX_W   = $clog2(MAX_IDX + 1);

   logic             is_row2;
   logic             is_hi;
   logic             byte_wr;
   logic [IDX_W-1:0] tgt_idx;
   logic             tgt_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= '0;
      else if (wr_en && wr_sel == SEL_POS)
         pos_q <= wr_data[POS_W-1:0];
   end

   always_comb begin
      is_row2 = (wr_sel == SEL_R2_LO) || (wr_sel == SEL_R2_HI);
      is_hi   = (wr_sel == SEL_R1_HI) || (wr_sel == SEL_R2_HI);
      byte_wr = wr_en && (wr_sel == SEL_R1_LO || wr_sel == SEL_R1_HI ||
                          wr_sel == SEL_R2_LO || wr_sel == SEL_R2_HI);
      tgt_idx = IDX_W'(pos_q) + (is_row2 ? IDX_W'(ROW_OFFSET) : IDX_W'(0));
      tgt_ok  = byte_wr && (tgt_idx < IDX_W'(STORE_WORDS));
   end

   for (genvar i = 0; i < STORE_WORDS; i++) begin : g_hit
      assign lo_en[i] = tgt_ok && !is_hi && (tgt_idx == IDX_W'(i));
      assign hi_en[i] = tgt_ok &&  is_hi && (tgt_idx == IDX_W'(i));
   end

endmodule

// File: rtl/alnum_word_store.sv
module alnum_word_store #(
   parameter int STORE_WORDS = 40,
   parameter int DATA_W      = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clear,
   input  logic [STORE_WORDS-1:0]            lo_en,
   input  logic [STORE_WORDS-1:0]            hi_en,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [STORE_WORDS*2*DATA_W-1:0]   store_flat
);
   localparam int WORD_W = 2 * DATA_W;

   for (genvar i = 0; i < STORE_WORDS; i++) begin : g_word
      logic [WORD_W-1:0] word_q;
      logic [WORD_W-1:0] merge;

      always_comb begin
         merge = {(hi_en[i] ? wr_data : '0), (lo_en[i] ? wr_data : '0)};
      end

      // The clear happens first, so a write in the tick cycle opens the new frame.
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else
            word_q <= (clear ? '0 : word_q) | merge;
      end

      assign store_flat[i*WORD_W +: WORD_W] = word_q;
   end

endmodule

// File: rtl/alnum_frame_publish.sv
module alnum_frame_publish
   import alnum_pkg::*;
#(
   parameter int STORE_WORDS = 40,
   parameter int ROW_OFFSET  = 20,
   parameter int PUB_PER_ROW = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                tick,
   input  logic [STORE_WORDS*SEG_W-1:0]        store_flat,
   output logic [2*PUB_PER_ROW*SEG_W-1:0]      frame_words,
   output logic                                frame_valid
);
   for (genvar r = 0; r < 2; r++) begin : g_row
      for (genvar k = 0; k < PUB_PER_ROW; k++) begin : g_dig
         localparam int SRC = r * ROW_OFFSET + k;
         localparam int DST = r * PUB_PER_ROW + k;
         logic [SEG_W-1:0] out_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               out_q <= '0;
            else if (tick)
               out_q <= seg_permute(store_flat[SRC*SEG_W +: SEG_W]);
         end

         assign frame_words[DST*SEG_W +: SEG_W] = out_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         frame_valid <= 1'b0;
      else
         frame_valid <= tick;
   end

endmodule

// File: rtl/alnum_frame_latch.sv
module alnum_frame_latch
   import alnum_pkg::*;
#(
   parameter int POS_W       = 5,
   parameter int STORE_WORDS = 40,
   parameter int ROW_OFFSET  = 20,
   parameter int PUB_PER_ROW = 16,
   parameter int DATA_W      = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [2:0]                        wr_sel,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic                              frame_tick,
   output logic [2*PUB_PER_ROW*2*DATA_W-1:0] frame_words,
   output logic                              frame_valid
);
   localparam int WORD_W = 2 * DATA_W;

   if (WORD_W != SEG_W) begin : g_bad_width
      $error("alnum_frame_latch: DATA_W must be half the segment word width");
   end
   if (ROW_OFFSET < PUB_PER_ROW) begin : g_bad_offset
      $error("alnum_frame_latch: published rows would overlap");
   end
   if (ROW_OFFSET + PUB_PER_ROW > STORE_WORDS) begin : g_bad_depth
      $error("alnum_frame_latch: store too small for the second row");
   end

   logic [POS_W-1:0]            pos_q;
   logic [STORE_WORDS-1:0]      lo_en;
   logic [STORE_WORDS-1:0]      hi_en;
   logic [STORE_WORDS*WORD_W-1:0] store_flat;

   alnum_reg_decode #(
      .POS_W(POS_W), .STORE_WORDS(STORE_WORDS),
      .ROW_OFFSET(ROW_OFFSET), .DATA_W(DATA_W)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .pos_q(pos_q), .lo_en(lo_en), .hi_en(hi_en)
   );

   alnum_word_store #(
      .STORE_WORDS(STORE_WORDS), .DATA_W(DATA_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .clear(frame_tick), .lo_en(lo_en),
      .hi_en(hi_en), .wr_data(wr_data), .store_flat(store_flat)
   );

   alnum_frame_publish #(
      .STORE_WORDS(STORE_WORDS), .ROW_OFFSET(ROW_OFFSET),
      .PUB_PER_ROW(PUB_PER_ROW)
   ) u_pub (
      .clk(clk), .rst_n(rst_n), .tick(frame_tick), .store_flat(store_flat),
      .frame_words(frame_words), .frame_valid(frame_valid)
   );

endmodule

// File: rtl/alnum_frame_latch_chk.sv
module alnum_frame_latch_chk #(
   parameter int POS_W       = 5,
   parameter int STORE_WORDS = 40,
   parameter int PUB_PER_ROW = 16,
   parameter int DATA_W      = 8
) (
   input logic                              clk,
   input logic                              rst_n,
   input logic                              wr_en,
   input logic [2:0]                        wr_sel,
   input logic [DATA_W-1:0]                 wr_data,
   input logic                              frame_tick,
   input logic [2*PUB_PER_ROW*2*DATA_W-1:0] frame_words,
   input logic                              frame_valid,
   input logic [POS_W-1:0]                  pos_q,
   input logic [STORE_WORDS*2*DATA_W-1:0]   store_flat
);
   logic pos_wr;
   assign pos_wr = wr_en && (wr_sel == 3'd0);

   p_pos_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pos_wr |=> pos_q == POS_W'($past(wr_data)));

   p_pos_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !pos_wr |=> $stable(pos_q));

   p_bits_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> (store_flat & $past(store_flat)) == $past(store_flat));

   p_valid_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      frame_tick |=> frame_valid);

   p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> !frame_valid);

   p_words_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_tick |=> $stable(frame_words));

   p_store_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && !wr_en) |=> store_flat == '0);

endmodule

bind alnum_frame_latch alnum_frame_latch_chk #(
   .POS_W(POS_W), .STORE_WORDS(STORE_WORDS),
   .PUB_PER_ROW(PUB_PER_ROW), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
   .wr_data(wr_data), .frame_tick(frame_tick), .frame_words(frame_words),
   .frame_valid(frame_valid), .pos_q(pos_q), .store_flat(store_flat)
);

// File: tb/sim_alnum_frame_latch.sv
module sim_alnum_frame_latch;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [2:0]   wr_sel = '0;
   logic [7:0]   wr_data = '0;
   logic         frame_tick = 1'b0;
   logic [511:0] frame_words;
   logic         frame_valid;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [15:0] mstore [40];
   logic [15:0] mexp   [32];
   logic [4:0]  mpos;
   int          order  [16] = '{7, 15, 12, 10, 8, 14, 13, 9, 11, 6, 5, 4, 3, 2, 1, 0};

   always #10 clk = ~clk;

   alnum_frame_latch u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .frame_tick(frame_tick),
      .frame_words(frame_words), .frame_valid(frame_valid)
   );

   function automatic logic [15:0] perm(input logic [15:0] w);
      logic [15:0] r;
      for (int j = 0; j < 16; j++) r[15-j] = w[order[j]];
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_wr(input logic [2:0] s, input logic [7:0] d);
      int idx;
      if (s == 3'd0) mpos = d[4:0];
      else if (s >= 3'd1 && s <= 3'd4) begin
         idx = int'(mpos) + ((s >= 3'd3) ? 20 : 0);
         if (idx < 40) begin
            if (s == 3'd2 || s == 3'd4) mstore[idx][15:8] |= d;
            else mstore[idx][7:0] |= d;
         end
      end
   endtask

   task automatic model_tick();
      for (int k = 0; k < 16; k++) begin
         mexp[k]    = perm(mstore[k]);
         mexp[16+k] = perm(mstore[20+k]);
      end
      for (int i = 0; i < 40; i++) mstore[i] = '0;
   endtask

   task automatic drive(input bit en, input logic [2:0] s, input logic [7:0] d, input bit t);
      @(negedge clk);
      wr_en = en; wr_sel = s; wr_data = d; frame_tick = t;
   endtask

   task automatic wr(input logic [2:0] s, input logic [7:0] d);
      drive(1'b1, s, d, 1'b0);
      model_wr(s, d);
   endtask

   // Tick (optionally with a coincident write), then check the published frame.
   task automatic tick_check(input string req, input bit en, input logic [2:0] s, input logic [7:0] d);
      drive(en, s, d, 1'b1);
      model_tick();
      if (en) model_wr(s, d);
      @(negedge clk);
      wr_en = 1'b0; frame_tick = 1'b0;
      chk(frame_valid === 1'b1, "R5 valid", {15'd0, frame_valid}, 16'd1);
      for (int k = 0; k < 32; k++)
         chk(frame_words[16*k +: 16] === mexp[k], req, frame_words[16*k +: 16], mexp[k]);
      @(negedge clk);
      chk(frame_valid === 1'b0, "R6 pulse", {15'd0, frame_valid}, 16'd0);
   endtask

   initial begin
      #3_000_000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 40; i++) mstore[i] = '0;
      mpos = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(frame_valid === 1'b0, "R10 valid", {15'd0, frame_valid}, 16'd0);
      for (int k = 0; k < 32; k++)
         chk(frame_words[16*k +: 16] === 16'd0, "R10 words", frame_words[16*k +: 16], 16'd0);
      rst_n = 1'b1;
      tick_check("R10 empty store", 1'b0, 3'd0, 8'd0);

      // R2 R3 R9 R1: sweep every position code, both rows, upper position bits set
      for (int p = 0; p < 32; p++) begin
         wr(3'd0, {3'b101, 5'(p)});
         wr(3'd1, 8'(p * 7 + 1));
         wr(3'd2, 8'(p) ^ 8'h5A);
         wr(3'd3, 8'(p * 3 + 2));
         wr(3'd4, ~8'(p));
      end
      tick_check("R2/R3/R9 sweep", 1'b0, 3'd0, 8'd0);

      // R9: row 1 position 17 is never published; position 22 lands on row 2 word 2
      wr(3'd0, 8'd17); wr(3'd1, 8'hFF); wr(3'd2, 8'hFF);
      tick_check("R9 hidden", 1'b0, 3'd0, 8'd0);
      wr(3'd0, 8'd22); wr(3'd1, 8'h3C);
      tick_check("R9 alias", 1'b0, 3'd0, 8'd0);

      // R4: OR accumulation
      wr(3'd0, 8'd3);
      wr(3'd1, 8'h01); wr(3'd1, 8'h10); wr(3'd1, 8'h80);
      wr(3'd2, 8'h02); wr(3'd2, 8'h40);
      wr(3'd4, 8'h81); wr(3'd4, 8'h18);
      tick_check("R4 accumulate", 1'b0, 3'd0, 8'd0);

      // R11: select 5..7 ignored; later write still lands at old position
      wr(3'd0, 8'd9);
      for (int s = 5; s < 8; s++) wr(3'(s), 8'hFF);
      wr(3'd1, 8'h66);
      tick_check("R11 ignored sel", 1'b0, 3'd0, 8'd0);

      // R8: walk one bit through every stored position
      for (int b = 0; b < 16; b++) begin
         wr(3'd0, 8'd0);
         if (b < 8) wr(3'd1, 8'(1 << b)); else wr(3'd2, 8'(1 << (b - 8)));
         tick_check("R8 bit order", 1'b0, 3'd0, 8'd0);
      end

      // R7: write coincident with tick goes to the next frame
      wr(3'd0, 8'd5); wr(3'd1, 8'h11);
      tick_check("R7 coincident excluded", 1'b1, 3'd2, 8'hA5);
      tick_check("R7 coincident next frame", 1'b0, 3'd0, 8'd0);

      // R6: output held while writes go on between ticks
      wr(3'd0, 8'd1); wr(3'd1, 8'h7E);
      tick_check("R6 setup", 1'b0, 3'd0, 8'd0);
      for (int i = 0; i < 6; i++) wr(3'd3, 8'(i + 1));
      @(negedge clk);
      wr_en = 1'b0;
      chk(frame_valid === 1'b0, "R6 no valid", {15'd0, frame_valid}, 16'd0);
      for (int k = 0; k < 32; k++)
         chk(frame_words[16*k +: 16] === mexp[k], "R6 held", frame_words[16*k +: 16], mexp[k]);
      tick_check("R6 next frame", 1'b0, 3'd0, 8'd0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule